// File: doc/BRIEF.md
# Two-Wire Bus Hang Recovery Sequencer

This block sits beside an open-drain two-wire serial bus and frees a bus whose data line has been left low by a slave that lost track of a transfer. It reads both bus lines through two-flop synchronizers. It watches for the data line staying low longer than a programmed limit. When that happens, or when software asks for it, the block drives the clock line itself. It pulls only low, through open-drain enables, and only a controlled number of times.

The block only ever pulls lines low, and it never pulls the data line while it is clocking. A slave that is still shifting out a byte therefore reads a not-acknowledge and lets go. Each high clock phase ends with a look at the data line. Once the line reads high, clocking stops and the block places a START and then a STOP on the bus, which leaves the bus idle. A slave that never lets go, or a clock line that never comes up, ends the sequence with a failure flag instead of an endless loop. No payload passes through the block, so there is no streaming interface. All pins are plain control and status signals.

Top module: `bus_unjam`

## Requirements
- R1: During and after reset, neither line is pulled, and `busy`, `done`, `recovered`, `failed` and `scl_stuck` are all 0.
- R2: While idle, a synchronized data line that stays low for `hang_limit` consecutive clocks starts recovery within a few clocks. A shorter low period starts nothing, and `hang_limit` = 0 turns automatic detection off.
- R3: A `kick` high while idle makes `busy` read 1 on the next clock edge. A `kick` while busy is ignored, and no second sequence follows.
- R4: Recovery emits at most `PULSES` (default 9) clock pulses. Each driven-low clock phase lasts exactly `half_period` clocks, and `half_period` must be at least 4.
- R5: The data line is sampled at the end of every high clock phase. If it reads high, clocking stops with that pulse.
- R6: The data line is never pulled while clock pulses are being issued. The first data-line pull of a sequence is the START.
- R7: After the data line is seen high, the block makes a START (data falls while clock is high) and then a STOP (data rises while clock is high), ends with both lines released, and sets `recovered`.
- R8: If the data line is still low after the last pulse, the block sets `failed`, issues neither START nor STOP, and returns to monitoring.
- R9: If the clock line is not seen high within `half_period` clocks after the block releases it, the sequence ends with `failed` and `scl_stuck` both set and both lines released.
- R10: `done` is a one-clock pulse in the first idle cycle after a sequence. It comes with exactly one of `recovered` or `failed`, and those flags hold until the next sequence starts, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hang_limit | input | HANG_W | Clocks of low data line that count as a hang; 0 disables detection |
| half_period | input | HALF_W | Length of each clock phase and of START/STOP setup and hold, in clocks |
| kick | input | 1 | Software request to start recovery at once |
| scl_in | input | 1 | Raw clock line level from the pad |
| sda_in | input | 1 | Raw data line level from the pad |
| scl_pull | output | 1 | Open-drain enable: 1 pulls the clock line low |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| busy | output | 1 | A recovery sequence is in progress |
| done | output | 1 | One-clock pulse at the end of every sequence |
| recovered | output | 1 | Last sequence freed the bus |
| failed | output | 1 | Last sequence could not free the bus |
| scl_stuck | output | 1 | Last failure was a clock line held low |

## Verification
A sequencer that loses its pulse count shows up on the clock pin during the same sequence: too many or too few rising clock edges before the START, or a START where a failure was due. A phase counter that runs wrong changes the width of the next low clock phase by at least one clock. A decode fault in the START/STOP states is visible within one half period, because the data line moves while the clock is low or the STOP never appears. Corrupted outcome flags are seen at the `done` pulse that ends the sequence.

// File: rtl/unjam_pkg.sv
package unjam_pkg;

  // Sequencer states; the pad enables are decoded from these.
  typedef enum logic [2:0] {
    ST_WATCH,     // monitoring, lines released
    ST_CLK_LO,    // clock pulled low
    ST_CLK_HI,    // clock released, waiting for it and sampling data
    ST_STA_HOLD,  // START: data pulled while clock is high
    ST_STA_LO,    // clock pulled behind the START
    ST_STO_HI,    // clock released, data still pulled
    ST_STO_END    // data released while clock high: STOP
  } unjam_state_t;

  typedef enum logic [1:0] {
    END_OK,
    END_SDA_LOW,
    END_SCL_LOW
  } unjam_end_t;

endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  // Idle bus lines are high, so both stages reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/unjam_hang_det.sv
module unjam_hang_det #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          sda_s,
  input  logic [CW-1:0] limit,
  output logic          hang
);

  logic [CW-1:0] low_cnt;

  // Counts consecutive low samples; saturates at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!armed || sda_s) begin
      low_cnt <= '0;
    end else if (low_cnt != limit) begin
      low_cnt <= low_cnt + CW'(1);
    end
  end

  assign hang = armed && !sda_s && (limit != '0) && (low_cnt == limit);

endmodule

// File: rtl/unjam_seq.sv
module unjam_seq
  import unjam_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PULSES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [HALF_W-1:0] half,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              busy,
  output logic              done,
  output logic              recovered,
  output logic              failed,
  output logic              scl_stuck
);

  localparam int PW = $clog2(PULSES + 1);
  localparam logic [PW-1:0] LAST = PW'(PULSES);

  unjam_state_t      state, nxt;
  unjam_end_t        kind;
  logic [HALF_W-1:0] cnt, half_m1;
  logic [PW-1:0]     pulses;
  logic              hi_seen;
  logic              phase_end, fin, restart, mark_hi, bump, launch;

  assign half_m1   = (half == '0) ? '0 : half - HALF_W'(1);
  assign phase_end = (cnt == half_m1);

  always_comb begin
    nxt     = state;
    fin     = 1'b0;
    kind    = END_OK;
    restart = 1'b0;
    mark_hi = 1'b0;
    bump    = 1'b0;
    launch  = 1'b0;
    case (state)
      ST_WATCH: begin
        if (start) begin
          nxt     = ST_CLK_LO;
          restart = 1'b1;
          launch  = 1'b1;
        end
      end
      ST_CLK_LO: begin
        if (phase_end) begin
          nxt     = ST_CLK_HI;
          restart = 1'b1;
          bump    = 1'b1;
        end
      end
      ST_CLK_HI: begin
        if (!hi_seen) begin
          if (scl_s) begin
            mark_hi = 1'b1;
            restart = 1'b1;
          end else if (phase_end) begin
            fin  = 1'b1;
            kind = END_SCL_LOW;
          end
        end else if (phase_end) begin
          restart = 1'b1;
          if (sda_s) begin
            nxt = ST_STA_HOLD;
          end else if (pulses == LAST) begin
            fin  = 1'b1;
            kind = END_SDA_LOW;
          end else begin
            nxt = ST_CLK_LO;
          end
        end
      end
      ST_STA_HOLD: begin
        if (phase_end) begin
          nxt     = ST_STA_LO;
          restart = 1'b1;
        end
      end
      ST_STA_LO: begin
        if (phase_end) begin
          nxt     = ST_STO_HI;
          restart = 1'b1;
        end
      end
      ST_STO_HI: begin
        if (!hi_seen) begin
          if (scl_s) begin
            mark_hi = 1'b1;
            restart = 1'b1;
          end else if (phase_end) begin
            fin  = 1'b1;
            kind = END_SCL_LOW;
          end
        end else if (phase_end) begin
          nxt     = ST_STO_END;
          restart = 1'b1;
        end
      end
      ST_STO_END: begin
        if (phase_end) begin
          fin  = 1'b1;
          kind = END_OK;
        end
      end
      default: nxt = ST_WATCH;
    endcase
    if (fin) begin
      nxt     = ST_WATCH;
      restart = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WATCH;
      cnt       <= '0;
      pulses    <= '0;
      hi_seen   <= 1'b0;
      done      <= 1'b0;
      recovered <= 1'b0;
      failed    <= 1'b0;
      scl_stuck <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= restart ? '0 : cnt + HALF_W'(1);
      done  <= fin;
      if (mark_hi) begin
        hi_seen <= 1'b1;
      end else if (restart) begin
        hi_seen <= 1'b0;
      end
      if (launch) begin
        pulses    <= '0;
        recovered <= 1'b0;
        failed    <= 1'b0;
        scl_stuck <= 1'b0;
      end else if (bump) begin
        pulses <= pulses + PW'(1);
      end
      if (fin) begin
        recovered <= (kind == END_OK);
        failed    <= (kind != END_OK);
        scl_stuck <= (kind == END_SCL_LOW);
      end
    end
  end

  assign busy     = (state != ST_WATCH);
  assign scl_pull = (state == ST_CLK_LO) || (state == ST_STA_LO);
  assign sda_pull = (state == ST_STA_HOLD) || (state == ST_STA_LO) ||
                    (state == ST_STO_HI);

endmodule

// File: rtl/bus_unjam.sv
module bus_unjam #(
  parameter int HANG_W = 32,
  parameter int HALF_W = 16,
  parameter int PULSES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HANG_W-1:0] hang_limit,
  input  logic [HALF_W-1:0] half_period,
  input  logic              kick,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              busy,
  output logic              done,
  output logic              recovered,
  output logic              failed,
  output logic              scl_stuck
);

  logic [1:0] lines_s;
  logic       hang;

  unjam_sync #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_in, sda_in}),
    .q    (lines_s)
  );

  unjam_hang_det #(.CW(HANG_W)) u_hang (
    .clk  (clk),
    .rst_n(rst_n),
    .armed(!busy),
    .sda_s(lines_s[0]),
    .limit(hang_limit),
    .hang (hang)
  );

  unjam_seq #(.HALF_W(HALF_W), .PULSES(PULSES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (kick || hang),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .half     (half_period),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .done     (done),
    .recovered(recovered),
    .failed   (failed),
    .scl_stuck(scl_stuck)
  );

endmodule

// File: rtl/unjam_chk.sv
module unjam_chk (
  input logic clk,
  input logic rst_n,
  input logic kick,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done,
  input logic recovered,
  input logic failed,
  input logic scl_stuck
);

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  p_kick_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && kick) |=> busy);

  p_start_clock_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_pull);

  p_stop_clock_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_pull);

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(recovered && failed));

  p_stuck_is_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_stuck |-> failed);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && (recovered || failed)));

  p_flags_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!recovered && !failed && !scl_stuck));

endmodule

bind bus_unjam unjam_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .kick     (kick),
  .scl_pull (scl_pull),
  .sda_pull (sda_pull),
  .busy     (busy),
  .done     (done),
  .recovered(recovered),
  .failed   (failed),
  .scl_stuck(scl_stuck)
);

// File: tb/test_bus_unjam.sv
module test_bus_unjam;
  localparam int HANG_W = 32;
  localparam int HALF_W = 16;
  localparam int HALF   = 8;
  localparam int LIMIT  = 50;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [HANG_W-1:0] hang_limit;
  logic [HALF_W-1:0] half_period;
  logic              kick;
  logic              scl_pull, sda_pull, busy, done, recovered, failed, scl_stuck;
  logic              scl_line, sda_line;

  // Slave model: holds data low until it has seen rel_after clock falls.
  logic hold_req, never_rel, slave_scl_hold, slave_sda_low;
  int   rel_after, falls, falls_base;
  logic sl_prev_scl;

  assign slave_sda_low = hold_req && (never_rel || (falls - falls_base) < rel_after);
  assign scl_line = !scl_pull && !slave_scl_hold;
  assign sda_line = !sda_pull && !slave_sda_low;

  bus_unjam #(.HANG_W(HANG_W), .HALF_W(HALF_W), .PULSES(9)) i_bus_unjam (
    .clk(clk), .rst_n(rst_n), .hang_limit(hang_limit), .half_period(half_period),
    .kick(kick), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done),
    .recovered(recovered), .failed(failed), .scl_stuck(scl_stuck)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  typedef struct {
    int    pulses;
    bit    rec;
    bit    fail;
    bit    stuck;
    string tag;
  } exp_t;
  exp_t sbq[$];

  task automatic expect_run(input int p, input bit r, input bit f, input bit s,
                            input string tag);
    exp_t e;
    e.pulses = p; e.rec = r; e.fail = f; e.stuck = s; e.tag = tag;
    sbq.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst_n) falls = 0;
    else if (sl_prev_scl && !scl_line) falls = falls + 1;
    sl_prev_scl = scl_line;
  end

  // Monitor: watches the bus lines and compares each finished run.
  int   busy_rises = 0;
  int   pulses_seen, starts, stops, lo_t;
  bit   start_seen, lo_valid;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_busy = 1'b0, prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        busy_rises++;
        pulses_seen = 0; starts = 0; stops = 0;
        start_seen = 0; lo_valid = 0;
      end
      if (busy) begin
        if (scl_line && !prev_scl && !start_seen) pulses_seen++;
        if (prev_scl && scl_line && prev_sda && !sda_line) begin
          starts++; start_seen = 1;
        end
        if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
        if (!scl_line && prev_scl) begin
          lo_t = 1; lo_valid = 1;
        end else if (!scl_line) begin
          lo_t++;
        end else if (!prev_scl && lo_valid) begin
          check(lo_t == HALF, "R4", "low clock phase width", lo_t, HALF);
          lo_valid = 0;
        end
        if (sda_pull && !start_seen && !scl_line)
          check(0, "R6", "data pulled during clocking", 1, 0);
      end
      if (done && prev_done) check(0, "R10", "done wider than one clock", 2, 1);
      if (done) begin
        if (sbq.size() == 0) begin
          check(0, "R3", "unexpected sequence end", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(pulses_seen == e.pulses, e.tag, "clock pulses", pulses_seen, e.pulses);
          check(recovered == e.rec, "R7", "recovered flag", recovered, e.rec);
          check(failed == e.fail, "R8", "failed flag", failed, e.fail);
          check(scl_stuck == e.stuck, "R9", "scl_stuck flag", scl_stuck, e.stuck);
          check(starts == int'(e.rec), "R7", "START count", starts, int'(e.rec));
          check(stops == int'(e.rec), "R7", "STOP count", stops, int'(e.rec));
          check(!scl_pull && !sda_pull, "R7", "lines released at end",
                int'({scl_pull, sda_pull}), 0);
        end
      end
    end
    prev_scl  = scl_line;
    prev_sda  = sda_line;
    prev_busy = busy;
    prev_done = done;
  end

  task automatic do_kick();
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    check(busy == 1'b1, "R3", "busy one clock after kick", busy, 1);
    check(!recovered && !failed, "R10", "flags cleared at start",
          int'({recovered, failed}), 0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R10", "done seen", done, 1);
  endtask

  task automatic slave_hold(input int k, input bit never);
    falls_base = falls;
    rel_after  = k;
    never_rel  = never;
    hold_req   = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int r0, n;
    rst_n = 1'b0; kick = 1'b0; hold_req = 1'b0; never_rel = 1'b0;
    slave_scl_hold = 1'b0; rel_after = 0; falls_base = 0;
    hang_limit = HANG_W'(LIMIT); half_period = HALF_W'(HALF);
    repeat (4) @(negedge clk);
    check(!scl_pull && !sda_pull && !busy && !done, "R1", "outputs in reset",
          int'({scl_pull, sda_pull, busy, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!recovered && !failed && !scl_stuck && !busy, "R1", "state after reset",
          int'({recovered, failed, scl_stuck, busy}), 0);

    // R2: short low period starts nothing.
    r0 = busy_rises;
    @(negedge clk); slave_hold(0, 1'b1);
    repeat (LIMIT - 10) @(negedge clk);
    hold_req = 1'b0;
    repeat (80) @(negedge clk);
    check(busy_rises == r0, "R2", "no start on short low", busy_rises - r0, 0);

    // R2/R5: long low triggers; slave lets go after 4 falls.
    expect_run(4, 1, 0, 0, "R5");
    @(negedge clk); slave_hold(4, 1'b0);
    n = 0;
    while (!busy && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n >= LIMIT && n <= LIMIT + 6, "R2", "hang detection delay", n, LIMIT + 3);
    wait_done();
    hold_req = 1'b0;
    repeat (30) @(negedge clk);
    check(recovered && !failed, "R10", "recovered flag holds",
          int'({recovered, failed}), 2);

    // R3/R5: kick on a free bus, one pulse then START/STOP.
    expect_run(1, 1, 0, 0, "R5");
    do_kick();
    wait_done();
    repeat (20) @(negedge clk);

    // R4: slave lets go only at the ninth pulse; extra kick ignored.
    r0 = busy_rises;
    expect_run(9, 1, 0, 0, "R4");
    slave_hold(9, 1'b0);
    do_kick();
    repeat (40) @(negedge clk);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    wait_done();
    hold_req = 1'b0;
    repeat (100) @(negedge clk);
    check(busy_rises - r0 == 1 && !busy, "R3", "kick while busy ignored",
          busy_rises - r0, 1);

    // R8: slave never lets go.
    expect_run(9, 0, 1, 0, "R8");
    slave_hold(0, 1'b1);
    do_kick();
    wait_done();
    hold_req = 1'b0;
    repeat (30) @(negedge clk);
    check(failed && !recovered, "R8", "failed flag holds",
          int'({failed, recovered}), 2);

    // R9: clock line held low by a slave.
    expect_run(0, 0, 1, 1, "R9");
    slave_scl_hold = 1'b1;
    do_kick();
    wait_done();
    slave_scl_hold = 1'b0;
    repeat (20) @(negedge clk);

    // R2: detection disabled with a zero limit.
    r0 = busy_rises;
    hang_limit = '0;
    slave_hold(0, 1'b1);
    repeat (300) @(negedge clk);
    hold_req = 1'b0;
    repeat (20) @(negedge clk);
    check(busy_rises == r0, "R2", "zero limit disables detection", busy_rises - r0, 0);

    check(sbq.size() == 0, "R10", "all expected runs ended", sbq.size(), 0);
    finish_sim();
  end

endmodule